// File: doc/BRIEF.md
# PDM Receiver Power-State Controller

This block decides when a PDM audio receiver may drive its output stage. It runs on a slow, free-running reference clock and follows four states: active playback, standby, full power-down and a timed wake interval. Standby is entered when the command decoder reports that the stop pattern has been accepted. That pattern is a run of the power-down byte covering roughly a thousand bit clocks. Full power-down is entered whenever the bit clock stops. The receiver returns through the wake interval once the bit clock runs again and real audio data appears.

The presence of the bit clock is judged in the reference domain. The PCLK side divides its clock and flips a toggle line. That line crosses into the reference domain through a two-flop synchronizer. The clock counts as lost after a parameterised number of reference cycles with no toggle. Each entry to full power-down, and the first cycle after reset, produces a one-cycle pulse. This pulse returns the configuration held elsewhere to its strapped defaults. The asynchronous reset stands in for the supply supervisor and disables the output without waiting for a clock edge.

Top module: `pdm_power_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` reads 2 (power-down) and `out_en`, `wake_done` and `cfg_clear` are 0. `cfg_clear` is high for exactly the first reference cycle after reset is released. State codes: 0 active, 1 standby, 2 power-down, 3 waking.
- R2: Clock loss is declared after `LOSS_CYCLES` reference cycles with no toggle. Suppose `pclk_tgl` last changes before reference edge n. In active state, `pwr_state` then still reads 0 after edge n+LOSS_CYCLES+2 and reads 2 after edge n+LOSS_CYCLES+3.
- R3: A toggle every `LOSS_CYCLES` reference cycles keeps the clock present. A toggle only every `LOSS_CYCLES`+1 cycles leads to power-down.
- R4: In active state with the clock present, `stop_seen` high moves the state to 1 on the next edge, and `out_en` falls with it.
- R5: Every entry to power-down raises `cfg_clear` for exactly one cycle, the first cycle in state 2.
- R6: Power-down is left, always to state 3, only when the clock is present, `data_live` is 1 and `stop_seen` is 0. `data_live` without a clock has no effect.
- R7: From standby with the clock present, `data_live` high with `stop_seen` low moves to state 3 without a `cfg_clear` pulse. Any other input combination keeps standby.
- R8: The waking state lasts exactly `WAKE_CYCLES` reference cycles with `out_en` low. The state then becomes 0, `out_en` rises, and `wake_done` is high for that first active cycle only.
- R9: If `stop_seen` is high when the wake interval ends, the state goes to 1 instead, with no `wake_done` pulse and `out_en` staying low.
- R10: Clock loss during the wake interval moves the state to 2.
- R11: Clock loss takes priority over `stop_seen`: when both are present in active state, the next state is 2.
- R12: Pulling `rst_n` low drops `out_en` at once, without any reference clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running low-rate reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply supervisor stand-in) |
| pclk_tgl | input | 1 | Toggle line flipped by the divided PDM bit clock |
| stop_seen | input | 1 | Stop pattern accepted by the command decoder (reference domain) |
| data_live | input | 1 | Non-stop data being received (reference domain) |
| pwr_state | output | 2 | Current state: 0 active, 1 standby, 2 power-down, 3 waking |
| cfg_clear | output | 1 | One-cycle pulse restoring strapped configuration defaults |
| out_en | output | 1 | Output stage enable |
| wake_done | output | 1 | One-cycle pulse on completing the wake interval |

## Verification
The assertions check these properties on every cycle:
- `cfg_clear` is a single-cycle pulse and accompanies each entry to power-down.
- Power-down is only left into the waking state.
- The active state is reached only from a completed wake, together with `wake_done`.
- A seen toggle restores clock presence, and a clock absent for two cycles keeps the output off.

The exact loss latency through the synchronizer, the toggle interval at the boundary, the wake length in cycles and the priority of clock loss over the stop flag depend on sequences built up over time. Only the bench scenarios show them, through sweeps of every start state against every stop and data combination, and through timed stops of the toggle line.

// File: rtl/pdm_pwr_pkg.sv
package pdm_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_OFF     = 2'd2,
    PS_WAKING  = 2'd3
  } pwr_state_e;

  // Transition rule: clock loss dominates, then the stop flag, then data.
  function automatic pwr_state_e pwr_next(input pwr_state_e cur,
                                          input logic alive,
                                          input logic stop,
                                          input logic live,
                                          input logic expire);
    pwr_state_e nxt;
    nxt = cur;
    unique case (cur)
      PS_ACTIVE: begin
        if (!alive)     nxt = PS_OFF;
        else if (stop)  nxt = PS_STANDBY;
      end
      PS_STANDBY: begin
        if (!alive)              nxt = PS_OFF;
        else if (live && !stop)  nxt = PS_WAKING;
      end
      PS_OFF: begin
        if (alive && live && !stop) nxt = PS_WAKING;
      end
      PS_WAKING: begin
        if (!alive)       nxt = PS_OFF;
        else if (expire)  nxt = stop ? PS_STANDBY : PS_ACTIVE;
      end
      default: nxt = PS_OFF;
    endcase
    return nxt;
  endfunction

  // Silence counter saturates at the limit; presence means below it.
  function automatic logic below_limit(input logic [31:0] cnt,
                                       input logic [31:0] lim);
    return cnt < lim;
  endfunction

endpackage

// File: rtl/pclk_presence.sv
module pclk_presence #(
  parameter int LOSS_CYCLES = 8
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic edge_o,
  output logic alive_o
);
  import pdm_pwr_pkg::*;

  localparam int CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(LOSS_CYCLES);

  logic [2:0]    sync_q;
  logic [CW-1:0] quiet_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tgl_in};
  end

  assign edge_o = sync_q[2] ^ sync_q[1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)            quiet_q <= LIM;
    else if (edge_o)       quiet_q <= '0;
    else if (quiet_q != LIM) quiet_q <= quiet_q + 1'b1;
  end

  assign alive_o = below_limit(32'(quiet_q), 32'(LOSS_CYCLES));

endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int WAKE_CYCLES = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic run,
  output logic expire_o
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] LAST = WW'(WAKE_CYCLES - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run && (cnt_q == LAST);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm (
  input  logic                    ref_clk,
  input  logic                    rst_n,
  input  logic                    alive,
  input  logic                    stop,
  input  logic                    live,
  input  logic                    expire,
  output pdm_pwr_pkg::pwr_state_e state_o,
  output logic                    cfg_clear_o,
  output logic                    wake_done_o,
  output logic                    enter_off_o
);
  import pdm_pwr_pkg::*;

  pwr_state_e state_q, state_d;
  logic       boot_q;

  assign state_d     = pwr_next(state_q, alive, stop, live, expire);
  assign enter_off_o = (state_d == PS_OFF) && (state_q != PS_OFF);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_OFF;
      boot_q      <= 1'b1;
      cfg_clear_o <= 1'b0;
      wake_done_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      boot_q      <= 1'b0;
      cfg_clear_o <= boot_q | enter_off_o;
      wake_done_o <= (state_q == PS_WAKING) && (state_d == PS_ACTIVE);
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pdm_power_ctrl.sv
module pdm_power_ctrl #(
  parameter int LOSS_CYCLES = 8,
  parameter int WAKE_CYCLES = 16
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pclk_tgl,
  input  logic       stop_seen,
  input  logic       data_live,
  output logic [1:0] pwr_state,
  output logic       cfg_clear,
  output logic       out_en,
  output logic       wake_done
);
  import pdm_pwr_pkg::*;

  logic       clk_alive;
  logic       pclk_edge;
  logic       wake_expire;
  logic       enter_off;
  pwr_state_e state;

  pclk_presence #(.LOSS_CYCLES(LOSS_CYCLES)) u_presence (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .tgl_in  (pclk_tgl),
    .edge_o  (pclk_edge),
    .alive_o (clk_alive)
  );

  wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .run      (state == PS_WAKING),
    .expire_o (wake_expire)
  );

  pwr_fsm u_fsm (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .alive       (clk_alive),
    .stop        (stop_seen),
    .live        (data_live),
    .expire      (wake_expire),
    .state_o     (state),
    .cfg_clear_o (cfg_clear),
    .wake_done_o (wake_done),
    .enter_off_o (enter_off)
  );

  assign pwr_state = state;
  assign out_en    = (state == PS_ACTIVE);

endmodule

// File: rtl/pdm_power_ctrl_chk.sv
module pdm_power_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       out_en,
  input logic       cfg_clear,
  input logic       wake_done,
  input logic       clk_alive,
  input logic       pclk_edge,
  input logic       wake_expire
);

  // R5
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> !cfg_clear);

  // R5
  off_entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && $past(state) != 2'd2) |-> cfg_clear);

  // R6
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd2 && state != 2'd2) |-> state == 2'd3);

  // R8
  active_from_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && $past(state) != 2'd0) |-> ($past(state) == 2'd3 && wake_done));

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !wake_expire && clk_alive) |=> state == 2'd3);

  // R8
  done_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> out_en);

  // R7
  standby_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == 2'd1 && state == 2'd3) |-> !cfg_clear);

  // R3
  edge_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_edge |=> clk_alive);

  // R2
  dead_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_alive && $past(!clk_alive)) |-> !out_en);

endmodule

bind pdm_power_ctrl pdm_power_ctrl_chk u_chk (
  .clk         (ref_clk),
  .rst_n       (rst_n),
  .state       (pwr_state),
  .out_en      (out_en),
  .cfg_clear   (cfg_clear),
  .wake_done   (wake_done),
  .clk_alive   (clk_alive),
  .pclk_edge   (pclk_edge),
  .wake_expire (wake_expire)
);

// File: tb/test_pdm_power_ctrl.sv
module test_pdm_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 6;
  localparam int WAKE = 10;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_tgl = 1'b0;
  logic       stop_seen = 1'b0;
  logic       data_live = 1'b0;
  logic [1:0] pwr_state;
  logic       cfg_clear, out_en, wake_done;

  int checks = 0;
  int errors = 0;
  bit pclk_on = 1'b1;
  int tgl_gap = 2;
  bit done = 1'b0;

  pdm_power_ctrl #(.LOSS_CYCLES(LOSS), .WAKE_CYCLES(WAKE)) i_pdm_power_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .pclk_tgl(pclk_tgl),
    .stop_seen(stop_seen), .data_live(data_live),
    .pwr_state(pwr_state), .cfg_clear(cfg_clear),
    .out_en(out_en), .wake_done(wake_done)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // divided bit-clock toggle source
  initial begin
    int n = 0;
    forever begin
      @(negedge ref_clk);
      if (pclk_on) begin
        n++;
        if (n >= tgl_gap) begin
          pclk_tgl = ~pclk_tgl;
          n = 0;
        end
      end else n = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench model of the state rule: 0 active, 1 standby, 2 off, 3 waking
  function automatic int model(input int s, input bit alive, input bit stop,
                               input bit live, input bit expire);
    if (s == 2) return (alive && live && !stop) ? 3 : 2;
    if (!alive) return 2;
    if (s == 0) return stop ? 1 : 0;
    if (s == 1) return (live && !stop) ? 3 : 1;
    if (expire) return stop ? 1 : 0;
    return 3;
  endfunction

  task automatic wait_state(input int s, input int lim);
    for (int i = 0; i < lim && pwr_state != 2'(s); i++) @(negedge ref_clk);
  endtask

  task automatic to_active();
    stop_seen = 0; data_live = 1;
    wait_state(0, 60);
    data_live = 0;
    @(negedge ref_clk);
  endtask

  task automatic to_off();
    pclk_on = 0;
    repeat (LOSS + 6) @(negedge ref_clk);
    pclk_on = 1;
    repeat (6) @(negedge ref_clk);
  endtask

  task automatic to_standby();
    to_active();
    stop_seen = 1;
    @(negedge ref_clk);
    stop_seen = 0;
    @(negedge ref_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int sv [3] = '{0, 1, 2};
    repeat (4) @(negedge ref_clk);
    // R1 state during reset
    chk("R1 state in reset", pwr_state, 2);
    chk("R1 out_en in reset", out_en, 0);
    chk("R1 clear in reset", cfg_clear, 0);
    chk("R1 done in reset", wake_done, 0);
    rst_n = 1;
    @(negedge ref_clk);
    chk("R1 clear first cycle", cfg_clear, 1);
    @(negedge ref_clk);
    chk("R1 clear second cycle", cfg_clear, 0);
    chk("R1 state after reset", pwr_state, 2);

    // R6 data without clock has no effect
    pclk_on = 0;
    repeat (LOSS + 6) @(negedge ref_clk);
    data_live = 1;
    repeat (5) @(negedge ref_clk);
    chk("R6 live without clock", pwr_state, 2);
    data_live = 0;
    pclk_on = 1;
    repeat (6) @(negedge ref_clk);

    // R8 wake length and completion
    data_live = 1;
    wait_state(3, 20);
    chk("R6 off exits to waking", pwr_state, 3);
    n = 0;
    while (pwr_state == 2'd3 && n < 100) begin
      chk("R8 out_en low while waking", out_en, 0);
      n++;
      @(negedge ref_clk);
    end
    chk("R8 wake length", n, WAKE);
    chk("R8 active after wake", pwr_state, 0);
    chk("R8 out_en after wake", out_en, 1);
    chk("R8 wake_done pulse", wake_done, 1);
    data_live = 0;
    @(negedge ref_clk);
    chk("R8 wake_done single", wake_done, 0);

    // R4, R6, R7 sweep: every start state against every stop/data pair
    foreach (sv[k]) begin
      for (int c = 0; c < 4; c++) begin
        int exp;
        if (sv[k] == 0) to_active();
        else if (sv[k] == 1) to_standby();
        else to_off();
        chk("R4 sweep start", pwr_state, sv[k]);
        stop_seen = c[1]; data_live = c[0];
        exp = model(sv[k], 1'b1, c[1], c[0], 1'b0);
        @(negedge ref_clk);
        chk(sv[k] == 0 ? "R4 sweep from active" :
            sv[k] == 1 ? "R7 sweep from standby" : "R6 sweep from off",
            pwr_state, exp);
        chk("R4 out_en matches state", out_en, exp == 0 ? 1 : 0);
        if (sv[k] == 1) chk("R7 no clear leaving standby", cfg_clear, 0);
        stop_seen = 0; data_live = 0;
        repeat (2) @(negedge ref_clk);
      end
    end

    // R5 standby loses clock
    to_standby();
    pclk_on = 0;
    wait_state(2, 40);
    chk("R5 standby to off", pwr_state, 2);
    chk("R5 clear on entry", cfg_clear, 1);
    @(negedge ref_clk);
    chk("R5 clear one cycle", cfg_clear, 0);
    pclk_on = 1;
    repeat (6) @(negedge ref_clk);

    // R2 exact loss latency, R11 priority of loss over stop
    to_active();
    @(pclk_tgl);
    pclk_on = 0;
    repeat (LOSS + 3) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R2 still active before loss", pwr_state, 0);
    stop_seen = 1;
    @(negedge ref_clk);
    chk("R2 off after loss window", pwr_state, 2);
    chk("R11 loss beats stop", pwr_state, 2);
    chk("R5 clear on loss", cfg_clear, 1);
    stop_seen = 0;
    pclk_on = 1;
    repeat (6) @(negedge ref_clk);

    // R3 boundary toggle intervals
    to_active();
    tgl_gap = LOSS;
    repeat (LOSS * 6) @(negedge ref_clk);
    chk("R3 gap at limit stays active", pwr_state, 0);
    tgl_gap = LOSS + 1;
    repeat (LOSS * 4 + 10) @(negedge ref_clk);
    chk("R3 gap over limit powers down", pwr_state, 2);
    tgl_gap = 2;
    repeat (6) @(negedge ref_clk);

    // R9 stop at wake expiry
    to_off();
    data_live = 1;
    wait_state(3, 20);
    data_live = 0;
    stop_seen = 1;
    wait_state(1, 40);
    chk("R9 wake ends in standby", pwr_state, 1);
    chk("R9 no wake_done", wake_done, 0);
    chk("R9 out_en low", out_en, 0);
    stop_seen = 0;
    @(negedge ref_clk);

    // R10 loss during wake
    data_live = 1;
    wait_state(3, 20);
    data_live = 0;
    pclk_on = 0;
    wait_state(2, WAKE + LOSS + 8);
    chk("R10 loss while waking", pwr_state, 2);
    pclk_on = 1;
    repeat (6) @(negedge ref_clk);

    // R12 asynchronous stop of the output
    to_active();
    chk("R12 active before reset", out_en, 1);
    #(CLK_PERIOD / 4);
    rst_n = 0;
    #1;
    chk("R12 out_en drops without edge", out_en, 0);
    chk("R12 state in reset", pwr_state, 2);
    @(negedge ref_clk);
    rst_n = 1;
    repeat (2) @(negedge ref_clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule